// File: doc/BRIEF.md
# Register-Mapped SPI Master with Completion and Collision Flags

This block is a byte-wide serial master for a small register bus. Software picks a bit rate and enables the block. It then writes a byte to the data register, and the block clocks that byte out on `mosi` while it captures a byte from `miso`. When the eighth bit has been exchanged, a completion flag is raised and an interrupt request can follow. The received byte is read back through the same data register.

Two flags report events. The completion flag can be cleared by an interrupt acknowledge. Both flags can also be cleared by a two-step software sequence: read the status register while the flag is set, then access the data register. A write to the data register while a byte is still moving is refused and raises the collision flag. A low level on the select input while the block is enabled as master is treated as a bus fault. The fault stops the transfer, takes away master mode and raises the completion flag.

The serial format is fixed. SCK idles low, the most significant bit goes first, MISO is sampled on the rising edge and MOSI changes on the falling edge.

Top module: `spi_flag_master`

## Requirements
- R1: After reset, the control (address 0), status (address 1) and data (address 2) registers read 0x00, and `sck` and `irq` are low.
- R2: The SCK period in system clocks is selected by {status bit 0, control bits 1:0}: 000→4, 001→16, 010→64, 011→128, 100→2, 101→8, 110→32, 111→64. A full byte takes 8 SCK periods, measured from the cycle after the data write to the cycle in which the completion flag sets.
- R3: A data write starts a transfer when control bit 3 (enable) and control bit 2 (master) are both one and no transfer is running. Bits leave MSB first, `sck` idles low, MISO is sampled on the rising edge, and after completion a data read returns the byte received.
- R4: Status bit 7 (completion) sets in the cycle after the last falling SCK edge of a transfer.
- R5: `irq` is high exactly while status bit 7 is one and control bit 4 (interrupt enable) is one.
- R6: A one-cycle pulse on `irq_ack` clears status bit 7.
- R7: A status read with bit 7 set, followed later by any data-register access, clears bit 7. A data access that is not preceded by such a status read leaves bit 7 unchanged.
- R8: A data write while a transfer is running sets status bit 6 (collision). The write is ignored, and the transfer goes on with the original byte.
- R9: A status read with bit 6 set, followed later by a data-register access, clears both bit 6 and bit 7.
- R10: While enable and master are set, `ss_n` held low (it is seen two clocks later through a synchronizer) aborts any transfer and returns `sck` low. It also clears control bit 2 and sets status bit 7.
- R11: Status bits 5 to 1 always read as zero. Status bit 0 is a read/write rate-doubling bit.
- R12: When a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| irq_ack | input | 1 | Interrupt acknowledge, clears completion |
| ss_n | input | 1 | Select input, low signals a bus fault in master mode |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| irq | output | 1 | Interrupt request |

## Verification
The end of a transfer and the second step of the software clear sequence can land on the same clock edge. In that case the completion flag is being set and cleared at once. The bench provokes this with the fastest rate. It starts a transfer, forces a collision, reads status to arm the clear, and then times a data read so that it is sampled on exactly the sixteenth edge after the start. The result is judged by reading status afterwards: the collision flag must be gone and the completion flag must remain set.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 7;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // control register bit positions
  localparam int C_IE  = 4;
  localparam int C_EN  = 3;
  localparam int C_MST = 2;
  // status register bit positions
  localparam int S_DONE = 7;
  localparam int S_WCOL = 6;
  localparam int S_DBL  = 0;

  // log2 of system clocks per SCK period; the table is not monotonic in its index
  function automatic logic [2:0] period_log2(input logic dbl, input logic [1:0] rate);
    logic [2:0] base;
    base = (rate == 2'd3) ? 3'd7 : ({rate, 1'b0} + 3'd2);
    return base - {2'b00, dbl};
  endfunction
endpackage

// File: rtl/spi_rate_sel.sv
module spi_rate_sel
  import spi_flag_pkg::*;
#(
  parameter int HALF_W = CNT_W
) (
  input  logic              dbl,
  input  logic [1:0]        rate,
  output logic [HALF_W-1:0] half_cnt
);
  logic [2:0] plog;

  always_comb begin
    plog     = period_log2(dbl, rate);
    half_cnt = HALF_W'(1) << (plog - 3'd1);
  end
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
  parameter int W      = 8,
  parameter int HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              start,
  input  logic [W-1:0]      wdata,
  input  logic [HALF_W-1:0] half_cnt,
  input  logic              abort,
  input  logic              miso,
  output logic              busy,
  output logic              fin,
  output logic              sck,
  output logic              mosi,
  output logic [W-1:0]      shreg
);
  localparam int BIT_W = $clog2(W);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(W - 1);

  logic              busy_q, busy_d, sck_q, sck_d, samp_q, samp_d;
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [W-1:0]      sh_q, sh_d;
  logic              tick;

  always_comb begin
    tick   = busy_q && (cnt_q >= half_cnt - HALF_W'(1));
    fin    = tick && sck_q && (bit_q == LAST);
    busy_d = busy_q;
    sck_d  = sck_q;
    samp_d = samp_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    if (abort) begin
      busy_d = 1'b0;
      sck_d  = 1'b0;
      cnt_d  = '0;
      bit_d  = '0;
    end else if (load) begin
      sh_d = wdata;
      if (start) begin
        busy_d = 1'b1;
        sck_d  = 1'b0;
        cnt_d  = '0;
        bit_d  = '0;
      end
    end else if (busy_q) begin
      if (tick) begin
        cnt_d = '0;
        sck_d = ~sck_q;
        if (!sck_q) begin
          samp_d = miso;                      // leading edge: sample
        end else begin
          sh_d  = {sh_q[W-2:0], samp_q};      // trailing edge: shift
          bit_d = bit_q + BIT_W'(1);
          if (fin) busy_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q + HALF_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      samp_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      samp_q <= samp_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
    end
  end

  assign busy  = busy_q;
  assign sck   = sck_q;
  assign mosi  = sh_q[W-1];
  assign shreg = sh_q;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy_q |-> !sck_q); // R3
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n) abort |=> (!busy_q && !sck_q)); // R10
  AST_FIN_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) fin |=> !busy_q); // R4
endmodule

// File: rtl/spi_flag_master.sv
module spi_flag_master
  import spi_flag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       irq_ack,
  input  logic       ss_n,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       irq
);
  logic [1:0] rate_q, rate_d;
  logic       ie_q, ie_d, en_q, en_d, mst_q, mst_d, dbl_q, dbl_d;
  logic       done_q, done_d, wcol_q, wcol_d;
  logic       arm_done_q, arm_done_d, arm_wcol_q, arm_wcol_d;
  logic [1:0] ss_sync_q;

  logic              wr_ctrl, wr_stat, wr_data, rd_stat, acc_data;
  logic              fault, load, start, collide, clr_done, clr_wcol;
  logic              busy, fin;
  logic [CNT_W-1:0]  half_cnt;
  logic [DATA_W-1:0] shreg;

  always_comb begin
    wr_ctrl  = bus_en && bus_wr && (bus_addr == ADDR_CTRL);
    wr_stat  = bus_en && bus_wr && (bus_addr == ADDR_STAT);
    acc_data = bus_en && (bus_addr == ADDR_DATA);
    wr_data  = acc_data && bus_wr;
    rd_stat  = bus_en && !bus_wr && (bus_addr == ADDR_STAT);
    fault    = en_q && mst_q && !ss_sync_q[1];
    load     = wr_data && !busy;
    start    = load && en_q && mst_q && !fault;
    collide  = wr_data && busy;
    clr_done = irq_ack || (acc_data && (arm_done_q || arm_wcol_q));
    clr_wcol = acc_data && arm_wcol_q;
  end

  always_comb begin
    rate_d     = wr_ctrl ? bus_wdata[1:0]  : rate_q;
    ie_d       = wr_ctrl ? bus_wdata[C_IE] : ie_q;
    en_d       = wr_ctrl ? bus_wdata[C_EN] : en_q;
    mst_d      = wr_ctrl ? bus_wdata[C_MST] : mst_q;
    if (fault) mst_d = 1'b0;
    dbl_d      = wr_stat ? bus_wdata[S_DBL] : dbl_q;
    // set takes precedence over clear
    done_d     = fin || fault || (done_q && !clr_done);
    wcol_d     = collide || (wcol_q && !clr_wcol);
    arm_done_d = arm_done_q;
    arm_wcol_d = arm_wcol_q;
    if (acc_data) begin
      arm_done_d = 1'b0;
      arm_wcol_d = 1'b0;
    end else if (rd_stat) begin
      arm_done_d = done_q;
      arm_wcol_d = wcol_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q     <= '0;
      ie_q       <= 1'b0;
      en_q       <= 1'b0;
      mst_q      <= 1'b0;
      dbl_q      <= 1'b0;
      done_q     <= 1'b0;
      wcol_q     <= 1'b0;
      arm_done_q <= 1'b0;
      arm_wcol_q <= 1'b0;
      ss_sync_q  <= 2'b11;
    end else begin
      rate_q     <= rate_d;
      ie_q       <= ie_d;
      en_q       <= en_d;
      mst_q      <= mst_d;
      dbl_q      <= dbl_d;
      done_q     <= done_d;
      wcol_q     <= wcol_d;
      arm_done_q <= arm_done_d;
      arm_wcol_q <= arm_wcol_d;
      ss_sync_q  <= {ss_sync_q[0], ss_n};
    end
  end

  spi_rate_sel #(.HALF_W(CNT_W)) rate_i (
    .dbl      (dbl_q),
    .rate     (rate_q),
    .half_cnt (half_cnt)
  );

  spi_shift_eng #(.W(DATA_W), .HALF_W(CNT_W)) eng_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .start    (start),
    .wdata    (bus_wdata),
    .half_cnt (half_cnt),
    .abort    (fault),
    .miso     (miso),
    .busy     (busy),
    .fin      (fin),
    .sck      (sck),
    .mosi     (mosi),
    .shreg    (shreg)
  );

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = {3'b000, ie_q, en_q, mst_q, rate_q};
      ADDR_STAT: bus_rdata = {done_q, wcol_q, 5'b00000, dbl_q};
      ADDR_DATA: bus_rdata = shreg;
      default:   bus_rdata = 8'h00;
    endcase
  end

  assign irq = done_q && ie_q;

  AST_COLLIDE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) collide |=> wcol_q); // R8
  AST_FAULT_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n) fault |=> (!mst_q && done_q)); // R10
  AST_FIN_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n) fin |=> done_q); // R12
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (irq_ack && !fin && !fault) |=> !done_q); // R6
endmodule

// File: tb/spi_flag_master_tb_top.sv
`timescale 1ns/1ps
module spi_flag_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0, bus_wr = 1'b0, irq_ack = 1'b0, ss_n = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sck, mosi, irq, miso;

  logic [7:0] slv_pat = 8'h00;
  logic [7:0] slv_rx;
  logic [2:0] slv_idx;
  logic       slv_rst = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  spi_flag_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ack(irq_ack), .ss_n(ss_n), .miso(miso), .sck(sck), .mosi(mosi), .irq(irq)
  );

  // serial slave model, mode 0
  always @(posedge sck) slv_rx <= {slv_rx[6:0], mosi};
  always @(negedge sck or posedge slv_rst)
    if (slv_rst) slv_idx <= 3'd0; else slv_idx <= slv_idx + 3'd1;
  assign miso = slv_pat[3'd7 - slv_idx];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling clock edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic slave_prep(input logic [7:0] p);
    slv_pat = p; slv_rst = 1'b1; #0.5 slv_rst = 1'b0;
  endtask

  function automatic int exp_period(input logic [2:0] sel);
    case (sel)
      3'd0: return 4;   3'd1: return 16;  3'd2: return 64;  3'd3: return 128;
      3'd4: return 2;   3'd5: return 8;   3'd6: return 32;  default: return 64;
    endcase
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); check("R1 ctrl", v, 8'h00);
    rd(2'd1, v); check("R1 status", v, 8'h00);
    rd(2'd2, v); check("R1 data", v, 8'h00);
    check("R1 sck", sck, 1'b0);
    check("R1 irq", irq, 1'b0);
  endtask

  task automatic t_status_bits();
    logic [7:0] v;
    wr(2'd1, 8'hFF); rd(2'd1, v); check("R11 reserved zero, dbl set", v, 8'h01);
    wr(2'd1, 8'h00); rd(2'd1, v); check("R11 dbl clear", v, 8'h00);
  endtask

  task automatic t_rates();
    logic [7:0] v;
    for (int s = 0; s < 8; s++) begin
      int cyc;
      logic [7:0] tx, pat;
      tx  = 8'h3C ^ 8'(s * 17);
      pat = 8'hA5 ^ 8'(s * 29);
      wr(2'd1, {7'd0, s[2]});
      wr(2'd0, {3'b000, 1'b1, 1'b1, 1'b1, s[1:0]});
      slave_prep(pat);
      wr(2'd2, tx);
      cyc = 0;
      while (!irq && cyc < 2000) begin @(negedge clk); cyc++; end
      check("R2 byte duration", cyc, 8 * exp_period(s[2:0]));
      check("R3 slave got MSB-first byte", slv_rx, tx);
      check("R3 sck idle after transfer", sck, 1'b0);
      rd(2'd2, v); check("R3 received byte", v, pat);
      rd(2'd1, v); check("R4 completion bit", v, {1'b1, 6'd0, s[2]});
      ack();
      check("R6 ack clears irq", irq, 1'b0);
      rd(2'd1, v); check("R6 ack clears completion", v, {7'd0, s[2]});
    end
    wr(2'd1, 8'h00);
  endtask

  task automatic t_irq_gate();
    logic [7:0] v;
    wr(2'd0, 8'h0D);              // en, master, rate 1, interrupts off
    slave_prep(8'h5A);
    wr(2'd2, 8'h11);
    repeat (140) @(negedge clk);
    check("R5 irq off when disabled", irq, 1'b0);
    wr(2'd0, 8'h1D);
    check("R5 irq once enabled", irq, 1'b1);
    rd(2'd2, v);                  // not armed: completion must stay
    check("R7 unarmed access keeps irq", irq, 1'b1);
    rd(2'd1, v); check("R7 flag still set", v, 8'h80);
    rd(2'd2, v);                  // armed: clears
    rd(2'd1, v); check("R7 two-step clear", v, 8'h00);
    check("R5 irq follows flag", irq, 1'b0);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    wr(2'd0, 8'h0D);
    slave_prep(8'hC3);
    wr(2'd2, 8'h96);
    repeat (10) @(negedge clk);
    wr(2'd2, 8'hFF);
    rd(2'd1, v); check("R8 collision flag", v, 8'h40);
    repeat (150) @(negedge clk);
    check("R8 transfer kept original byte", slv_rx, 8'h96);
    rd(2'd1, v); check("R9 both flags set", v, 8'hC0);
    rd(2'd2, v); check("R8 received byte intact", v, 8'hC3);
    rd(2'd1, v); check("R9 both flags cleared", v, 8'h00);
  endtask

  task automatic t_fault();
    logic [7:0] v;
    wr(2'd0, 8'h1F);              // slowest rate
    slave_prep(8'h00);
    wr(2'd2, 8'h81);
    repeat (70) @(negedge clk);
    ss_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R10 sck returned low", sck, 1'b0);
    check("R10 irq on fault", irq, 1'b1);
    rd(2'd0, v); check("R10 master bit cleared", v, 8'h1B);
    repeat (200) @(negedge clk);
    check("R10 no further sck", sck, 1'b0);
    ss_n = 1'b1;
    repeat (3) @(negedge clk);
    ack();
    rd(2'd1, v); check("R10 flag cleared after fault", v, 8'h00);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    wr(2'd1, 8'h01);              // fastest rate: 16 clocks per byte
    wr(2'd0, 8'h0C);
    slave_prep(8'h00);
    wr(2'd2, 8'h55);              // sampled at P0, now at N0
    @(negedge clk);               // N1
    wr(2'd2, 8'hAA);              // collision at P2, now N2
    @(negedge clk);               // N3
    rd(2'd1, v);                  // arms collision clear at P4, now N4
    check("R12 collision seen", v, 8'h41);
    repeat (11) @(negedge clk);   // N15
    rd(2'd2, v);                  // data access sampled at P16 = completion
    rd(2'd1, v); check("R12 set wins over clear", v, 8'h81);
    rd(2'd2, v);
    rd(2'd1, v); check("R12 cleanup", v, 8'h01);
    wr(2'd1, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status_bits();
    t_rates();
    t_irq_gate();
    t_collision();
    t_fault();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule